// File: doc/BRIEF.md
# Byte-Bus Counter/Timer with Masked Interrupt

This block is a 16-bit down-counter driven through a small byte-wide register bus. It carries an interrupt status byte and an interrupt enable mask. Software writes the reload value as two bytes. It starts and stops the counter by reading two fixed command addresses; the read itself is the command. Stopping halts the counter, snapshots the live count into two readable value bytes, and clears the counter-ready flag. While the counter runs, it counts down once per `tick_en` pulse. Each time it expires, it sets counter-ready and reloads from the preset.

A timeout mode, selected by the `tmo_mode` pin, turns the counter into a watchdog. Each `tmo_restart` pulse reloads it and clears counter-ready. Counter-ready is set only if the count runs out before the next restart. In this mode the start and stop reads do nothing.

The other seven status bits come from neighbouring logic as plain inputs and appear unchanged in the status byte. The single active-low interrupt line is registered. It goes low while any status bit is set together with its enable bit.

Top module: `ctmr_top`

## Requirements
- R1: Address 0x0 holds the preset upper byte, address 0x1 holds the preset lower byte, and address 0x5 holds the interrupt mask. All three are writable and read back what was written.
- R2: In normal mode (`tmo_mode`=0), a bus read at address 0xE loads the counter with the 16-bit preset and sets it running.
- R3: In normal mode, a bus read at address 0xF halts the counter and clears counter-ready. This clear takes priority over an expiry in the same cycle.
- R4: The read at address 0xF in normal mode also copies the current count into the value registers. Address 0x2 reads the upper byte and address 0x3 reads the lower byte.
- R5: While `tmo_mode`=1, reads at 0xE and 0xF leave the count, the value registers and counter-ready unchanged.
- R6: In normal mode, a running counter decrements on each `tick_en` cycle. A tick that finds the count at 1 or 0 sets counter-ready and reloads the preset. With preset P≥1, counter-ready therefore sets after P ticks and the count after k ticks is P − (k mod P). With preset 0, it sets on the first tick and the count stays 0.
- R7: Address 0x4 reads the status byte. Bit 3 is counter-ready. Bits 7..4 and 2..0 are `status_in` bits 7..4 and 2..0, and `status_in[3]` is ignored. The mask has no effect on this value.
- R8: `irq_n` equals the NOR of (status AND mask) as it was one clock earlier.
- R9: After reset the mask, the preset, the value registers and counter-ready are 0, and `irq_n` is 1.
- R10: In timeout mode, a `tmo_restart` pulse reloads the preset, clears counter-ready and arms the counter. With preset P≥1, the P-th tick after a restart sets counter-ready and halts the count at 0 until the next restart.
- R11: Read data appears on `bus_rdata` in the cycle after the read. Reads at 0xE, 0xF and unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick_en | input | 1 | Count enable pulse |
| tmo_mode | input | 1 | 1 selects timeout mode |
| tmo_restart | input | 1 | Timeout-mode reload pulse |
| status_in | input | 8 | External status bits (bit 3 unused) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest state to reach from the ports is a snapshot of the count at an arbitrary point in its reload cycle. The count is only visible after a stop read, so its value depends on the exact number of ticks seen since start, across any wraps. The stimulus draws random presets and random tick counts from a fixed seed, with idle gaps between ticks. The expected snapshot and ready bit are derived from the tick count alone. Directed cases add preset 0, preset 1, a full-scale preset, and timeout windows that are restarted just one tick before expiry.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] ADR_PRE_HI = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_PRE_LO = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_VAL_HI = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_VAL_LO = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_STAT   = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_MASK   = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_START  = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_STOP   = 4'hF;
    localparam int RDY_BIT = 3;
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [2*BYTE_W-1:0]   preset,
    output logic [BYTE_W-1:0]     mask
);
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] msk;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                ADR_PRE_HI: r_d.hi  = wdata;
                ADR_PRE_LO: r_d.lo  = wdata;
                ADR_MASK:   r_d.msk = wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign preset = {r_q.hi, r_q.lo};
    assign mask   = r_q.msk;
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  logic             tmo,
    input  logic             restart,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] latch,
    output logic             ready
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lat;
        logic             run;
        logic             rdy;
    } core_t;

    core_t c_d, c_q;
    logic  expire;

    always_comb begin
        c_d    = c_q;
        expire = tick && c_q.run && (c_q.cnt <= ONE);
        if (tmo) begin
            if (restart) begin
                c_d.cnt = preset;
                c_d.run = 1'b1;
                c_d.rdy = 1'b0;
            end else if (expire) begin
                c_d.cnt = '0;
                c_d.run = 1'b0;
                c_d.rdy = 1'b1;
            end else if (tick && c_q.run) begin
                c_d.cnt = c_q.cnt - ONE;
            end
        end else begin
            if (stop) begin
                c_d.run = 1'b0;
                c_d.rdy = 1'b0;
                c_d.lat = c_q.cnt;
            end else if (start) begin
                c_d.cnt = preset;
                c_d.run = 1'b1;
            end else if (expire) begin
                c_d.cnt = preset;
                c_d.rdy = 1'b1;
            end else if (tick && c_q.run) begin
                c_d.cnt = c_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.cnt;
    assign latch = c_q.lat;
    assign ready = c_q.rdy;
endmodule

// File: rtl/ctmr_irq.sv
module ctmr_irq
    import ctmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] status_in,
    input  logic              ready,
    input  logic [BYTE_W-1:0] mask,
    output logic [BYTE_W-1:0] status,
    output logic              irq_n
);
    typedef struct packed {
        logic irq_n;
    } irq_t;

    irq_t i_d, i_q;
    logic [BYTE_W-1:0] st;

    always_comb begin
        st          = status_in;
        st[RDY_BIT] = ready;
        i_d.irq_n   = ~|(st & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '{irq_n: 1'b1};
        else        i_q <= i_d;
    end

    assign status = st;
    assign irq_n  = i_q.irq_n;
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tick_en,
    input  logic              tmo_mode,
    input  logic              tmo_restart,
    input  logic [7:0]        status_in,
    output logic              irq_n
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0]  preset_w;
    logic [BYTE_W-1:0] mask_w;
    logic [CNT_W-1:0]  count_w;
    logic [CNT_W-1:0]  latch_w;
    logic              ready_w;
    logic [BYTE_W-1:0] status_w;
    logic              start_cmd;
    logic              stop_cmd;

    assign start_cmd = bus_rd && (bus_addr == ADR_START);
    assign stop_cmd  = bus_rd && (bus_addr == ADR_STOP);

    ctmr_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .preset (preset_w),
        .mask   (mask_w)
    );

    ctmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_cmd),
        .stop    (stop_cmd),
        .tick    (tick_en),
        .tmo     (tmo_mode),
        .restart (tmo_restart),
        .preset  (preset_w),
        .count   (count_w),
        .latch   (latch_w),
        .ready   (ready_w)
    );

    ctmr_irq #(.BYTE_W(BYTE_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_in (status_in),
        .ready     (ready_w),
        .mask      (mask_w),
        .status    (status_w),
        .irq_n     (irq_n)
    );

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            case (bus_addr)
                ADR_PRE_HI: rd_d.rdata = preset_w[CNT_W-1:BYTE_W];
                ADR_PRE_LO: rd_d.rdata = preset_w[BYTE_W-1:0];
                ADR_VAL_HI: rd_d.rdata = latch_w[CNT_W-1:BYTE_W];
                ADR_VAL_LO: rd_d.rdata = latch_w[BYTE_W-1:0];
                ADR_STAT:   rd_d.rdata = status_w;
                ADR_MASK:   rd_d.rdata = mask_w;
                default:    rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd,
    input logic [3:0]        addr,
    input logic              tmo,
    input logic              tick,
    input logic [CNT_W-1:0]  preset,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  latch,
    input logic              ready,
    input logic [BYTE_W-1:0] status,
    input logic [BYTE_W-1:0] mask,
    input logic              irq_n
);
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 4'hE && !tmo) |=> (count == $past(preset)));

    p_stop_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 4'hF && !tmo) |=> !ready);

    p_stop_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 4'hF && !tmo) |=> (latch == $past(count)));

    p_tmo_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 4'hF && tmo) |=> ($stable(latch) && $stable(ready)));

    p_ready_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tick));

    p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == ~|($past(status) & $past(mask))));
endmodule

bind ctmr_top ctmr_checker #(.CNT_W(2 * BYTE_W), .BYTE_W(BYTE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .tmo    (tmo_mode),
    .tick   (tick_en),
    .preset (preset_w),
    .count  (count_w),
    .latch  (latch_w),
    .ready  (ready_w),
    .status (status_w),
    .mask   (mask_w),
    .irq_n  (irq_n)
);

// File: tb/test_ctmr_top.sv
module test_ctmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_en = 1'b0;
    logic       tmo_mode = 1'b0;
    logic       tmo_restart = 1'b0;
    logic [7:0] status_in = '0;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ctmr_top i_ctmr_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .tmo_mode(tmo_mode), .tmo_restart(tmo_restart),
        .status_in(status_in), .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
            if ($urandom_range(0, 1) == 1) @(negedge clk);
        end
    endtask

    task automatic restart_pulse();
        @(negedge clk); tmo_restart = 1'b1;
        @(negedge clk); tmo_restart = 1'b0;
    endtask

    function automatic int exp_cnt(input int p, input int k);
        if (p == 0) return 0;
        return p - (k % p);
    endfunction

    function automatic int exp_rdy(input int p, input int k);
        if (p == 0) return (k >= 1) ? 1 : 0;
        return (k >= p) ? 1 : 0;
    endfunction

    function automatic int exp_stat(input logic [7:0] sin, input int rdy);
        return int'((sin & 8'hF7) | (rdy != 0 ? 8'h08 : 8'h00));
    endfunction

    function automatic int exp_irq(input logic [7:0] sin, input int rdy, input logic [7:0] m);
        logic [7:0] s;
        s = 8'(exp_stat(sin, rdy));
        return (|(s & m)) ? 0 : 1;
    endfunction

    task automatic normal_run(input int p, input int k);
        logic [7:0] d, hi, lo;
        bus_write(4'h0, 8'(p >> 8));
        bus_write(4'h1, 8'(p));
        bus_read(4'hE, d);
        check("R11 start read returns 0", d, 0);
        ticks(k);
        bus_read(4'h4, d);
        check("R6 ready before stop", int'(d[3]), exp_rdy(p, k));
        bus_read(4'hF, d);
        check("R11 stop read returns 0", d, 0);
        bus_read(4'h2, hi);
        bus_read(4'h3, lo);
        check("R4 R6 latched count", int'({hi, lo}), exp_cnt(p, k));
        bus_read(4'h4, d);
        check("R3 ready cleared by stop", int'(d[3]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, hi, lo, m, sin;
        int p, k, rdy, prev_irq;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R9 irq_n after reset", int'(irq_n), 1);
        bus_read(4'h5, d);  check("R9 mask after reset", d, 0);
        bus_read(4'h2, hi); bus_read(4'h3, lo);
        check("R9 value after reset", int'({hi, lo}), 0);
        bus_read(4'h4, d);  check("R9 R7 status after reset", d, 0);
        bus_read(4'h0, d);  check("R9 preset after reset", d, 0);

        // register read-back
        bus_write(4'h0, 8'hA5); bus_write(4'h1, 8'h3C); bus_write(4'h5, 8'h00);
        bus_read(4'h0, d); check("R1 preset hi", d, 8'hA5);
        bus_read(4'h1, d); check("R1 preset lo", d, 8'h3C);
        bus_read(4'h9, d); check("R11 unmapped read", d, 0);

        // directed counter corners
        normal_run(0, 3);
        normal_run(1, 4);
        normal_run(16'hFFFF, 5);
        normal_run(5, 4);
        normal_run(5, 5);
        normal_run(5, 12);

        // random counter runs
        for (int it = 0; it < 24; it++) begin
            p = $urandom_range(1, 40);
            k = $urandom_range(0, 90);
            normal_run(p, k);
        end

        // status read and mask / irq
        for (int it = 0; it < 16; it++) begin
            sin = 8'($urandom);
            m   = 8'($urandom);
            @(negedge clk); status_in = sin;
            bus_write(4'h5, m);
            @(negedge clk);
            check("R8 irq_n masked status", int'(irq_n), exp_irq(sin, 0, m));
            bus_read(4'h4, d);
            check("R7 status unaffected by mask", d, exp_stat(sin, 0));
            bus_read(4'h5, d);
            check("R1 mask readback", d, m);
        end

        // irq latency: one clock
        bus_write(4'h5, 8'h01);
        @(negedge clk); status_in = 8'h00;
        @(negedge clk);
        prev_irq = int'(irq_n);
        check("R8 irq idle", prev_irq, 1);
        status_in = 8'h01;
        #1 check("R8 irq not yet updated", int'(irq_n), 1);
        @(negedge clk);
        check("R8 irq one clock later", int'(irq_n), 0);
        status_in = 8'h08;
        @(negedge clk);
        check("R7 status_in bit3 ignored", int'(irq_n), 1);
        bus_write(4'h5, 8'h00);

        // leave a known latch value in normal mode
        normal_run(9, 2);

        // timeout mode
        @(negedge clk); tmo_mode = 1'b1; status_in = 8'h00;
        p = $urandom_range(3, 20);
        bus_write(4'h0, 8'(p >> 8)); bus_write(4'h1, 8'(p));
        restart_pulse();
        ticks(p - 1);
        bus_read(4'h4, d); check("R10 not expired yet", int'(d[3]), 0);
        restart_pulse();
        ticks(p - 1);
        bus_read(4'h4, d); check("R10 restart reloads window", int'(d[3]), 0);
        ticks(1);
        bus_read(4'h4, d); check("R10 expiry sets ready", int'(d[3]), 1);
        ticks(p + 3);
        bus_read(4'h4, d); check("R10 ready holds after expiry", int'(d[3]), 1);
        bus_read(4'hF, d);
        bus_read(4'h4, d); check("R5 stop keeps ready", int'(d[3]), 1);
        bus_read(4'h2, hi); bus_read(4'h3, lo);
        check("R5 stop keeps latch", int'({hi, lo}), 7);
        bus_write(4'h5, 8'h08);
        @(negedge clk);
        check("R8 counter ready raises irq", int'(irq_n), 0);
        bus_read(4'hE, d);
        bus_read(4'h4, d); check("R5 start keeps ready", int'(d[3]), 1);
        restart_pulse();
        bus_read(4'h4, d); check("R10 restart clears ready", int'(d[3]), 0);
        @(negedge clk);
        check("R8 irq released", int'(irq_n), 1);
        ticks(p - 1);
        bus_read(4'hE, d);
        ticks(1);
        bus_read(4'h4, d); check("R5 start does not reload", int'(d[3]), 1);

        // back to normal mode: latch still from the earlier stop
        @(negedge clk); tmo_mode = 1'b0;
        bus_read(4'h2, hi); bus_read(4'h3, lo);
        check("R5 latch intact after timeout mode", int'({hi, lo}), 7);
        bus_read(4'hF, d);
        bus_read(4'h4, d); check("R3 stop clears ready", int'(d[3]), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule